// File: doc/BRIEF.md
# SMI Event Status and Enable Register

This block is one 32-bit control and status word for a host-controller function. It gathers the events that should call system-management firmware and drives one SMI request line. Three events are latched and held until software clears them: a write to the controller's base address register, a write to its command register, and any change of the semaphore that says the operating system owns the controller. Next to these, the word shows a live read-only copy of six status bits that live in the controller's operational status register. Three read/write enable bits decide which latched events reach the SMI output.

Software reads the whole word through a 32-bit read port and writes it through a byte-enabled write port. The bus decoder outside the block asserts the write strobe only when this dword is addressed. A latched event is cleared by writing 1 to its bit. The block belongs to the suspend power domain, so its only reset is the suspend-domain reset.

Top module: `smi_evt_reg`

## Requirements
- R1: After reset every stored bit is 0: with all six status inputs at 0 the read word is 00000000h and the SMI output is 0.
- R2: A one-cycle pulse on the base-address-write input sets bit 31 on the next clock edge. Writing 1 to bit 31 with byte enable 3 clears it on the next edge.
- R3: A one-cycle pulse on the command-write input sets bit 30 on the next clock edge. It is cleared by writing 1 to bit 30 with byte enable 3.
- R4: A change of the semaphore input in either direction sets bit 29 two clock edges after the new value is first sampled. Releasing reset with the semaphore at its reset value (0) sets nothing. Bit 29 is cleared by writing 1 to it with byte enable 3.
- R5: Writing 0 to an event bit leaves it unchanged, and so does a write whose byte enable 3 is 0.
- R6: If an event and a write-1-to-clear of the same bit fall on the same clock edge, the bit ends at 1.
- R7: Bits 21 to 16 always equal the status input, bit 21 being input bit 5 (async advance) down to bit 16 being input bit 0 (transfer complete). No write changes them.
- R8: Bits 15, 14 and 13 are the read/write enables for bits 31, 30 and 29. They load from the write data when byte enable 1 is set.
- R9: Bits 28 to 22 and 12 to 0 always read 0, whatever is written.
- R10: The SMI output is 1 exactly one clock edge after some event bit and its enable are both 1. It goes back to 0 one edge after no such pair remains.
- R11: The reset is synchronous and active low. It clears events, enables, the semaphore history and the SMI output, and any event that arrives while it is held is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_sus_n | input | 1 | Suspend-domain reset, synchronous, active low |
| bar_wr_evt | input | 1 | One-cycle pulse when the base address register is written |
| cmd_wr_evt | input | 1 | One-cycle pulse when the command register is written |
| os_own_sem | input | 1 | Level of the OS-ownership semaphore |
| hc_sts | input | 6 | Live status bits: 5 async advance, 4 host system error, 3 frame list rollover, 2 port change, 1 transfer error, 0 transfer complete |
| wr_en | input | 1 | Write strobe for this dword |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read word |
| smi_req | output | 1 | Registered SMI request level |

## Verification
The bench aims at the edge where an event pulse and a write-1-to-clear of the same bit meet. A design that let the clear win would lose that event and read 0. It toggles the semaphore both ways and releases reset with the semaphore low, so a detector that catches only one direction, or that fires on reset, shows up as a missing or extra bit 29. It writes all ones with various byte enables while the status inputs change. A design that let the shadow bits be written, took lanes it should ignore, or held reserved bits would read back a wrong word. The SMI output is checked on the exact cycle after an enable and an event pair up and after they part, so a combinational or two-stage path is off by one cycle.

// File: rtl/smi_evt_pkg.sv
// Package: smi_evt_pkg
// Bit layout and sizes shared by the SMI event register modules.
// Assumes a 32-bit word; the event, shadow and enable fields are contiguous.
package smi_evt_pkg;
    localparam int WORD_W  = 32;
    localparam int N_EVT   = 3;   // latched events: [2] BAR write, [1] command write, [0] semaphore change
    localparam int EVT_LSB = 29;  // event field occupies 31:29
    localparam int N_STS   = 6;   // mirrored status bits
    localparam int STS_LSB = 16;  // shadow field occupies 21:16
    localparam int EN_LSB  = 13;  // enable field occupies 15:13, same order as events
    localparam int EVT_LANE = EVT_LSB / 8;
    localparam int EN_LANE  = EN_LSB / 8;
endpackage

// File: rtl/smi_sticky_evt.sv
// Module: smi_sticky_evt
// A row of sticky event bits: an event pulse sets a bit, a clear request
// resets it, and on a clash the set wins so no event is lost.
// Assumes set and clear requests are already qualified by the caller.
module smi_sticky_evt #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] evt_o
);
    logic [N-1:0] evt_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Holds one event until software clears it; set has priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                evt_q[i] <= 1'b0;
            else if (set_i[i])
                evt_q[i] <= 1'b1;
            else if (clr_i[i])
                evt_q[i] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> evt_q[i]); // R6
        AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !evt_q[i]); // R2
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[i] && !set_i[i]) |=> $stable(evt_q[i])); // R5
    end

    assign evt_o = evt_q;
endmodule

// File: rtl/smi_sem_edge.sv
// Module: smi_sem_edge
// Samples the ownership semaphore once and flags any change between two
// consecutive samples, in either direction.
// Assumes the semaphore is synchronous to clk; both sample stages reset to
// SEM_RST so a semaphore resting at that value gives no event on reset.
module smi_sem_edge #(
    parameter logic SEM_RST = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sem_i,
    output logic chg_o
);
    logic sem_q;
    logic sem_prev_q;

    // Two-stage sample history of the semaphore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sem_q      <= SEM_RST;
            sem_prev_q <= SEM_RST;
        end else begin
            sem_q      <= sem_i;
            sem_prev_q <= sem_q;
        end
    end

    // A change shows as a difference between the two stages.
    always_comb chg_o = sem_q ^ sem_prev_q;

    AST_SEM_CHANGE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (sem_i != $past(sem_i))) |=> chg_o); // R4
    AST_SEM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (sem_i == $past(sem_i))) |=> !chg_o); // R4
endmodule

// File: rtl/smi_en_ctl.sv
// Module: smi_en_ctl
// Holds the per-event enables and forms the registered SMI request level
// from the enabled latched events.
// Assumes the write qualifier is already decoded for the enable byte lane.
module smi_en_ctl #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_wr_i,
    input  logic [N-1:0] en_d_i,
    input  logic [N-1:0] evt_i,
    output logic [N-1:0] en_o,
    output logic         smi_o
);
    logic [N-1:0] en_q;
    logic         smi_q;

    // Enable bits load from software writes to their byte lane.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (en_wr_i)
            en_q <= en_d_i;
    end

    // SMI level: OR of enabled events, registered once.
    always_ff @(posedge clk) begin
        if (!rst_n)
            smi_q <= 1'b0;
        else
            smi_q <= |(evt_i & en_q);
    end

    assign en_o  = en_q;
    assign smi_o = smi_q;

    AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr_i |=> (en_q == $past(en_d_i))); // R8
    AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr_i |=> $stable(en_q)); // R8
endmodule

// File: rtl/smi_evt_reg.sv
// Module: smi_evt_reg
// SMI event status and enable register: three sticky write-1-to-clear
// events, six read-only status shadows, three enables, one SMI level.
// Assumes the bus decoder raises wr_en only for this dword and that the
// reset is the suspend-domain reset.
module smi_evt_reg
    import smi_evt_pkg::*;
#(
    parameter logic SEM_RST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_sus_n,
    input  logic              bar_wr_evt,
    input  logic              cmd_wr_evt,
    input  logic              os_own_sem,
    input  logic [N_STS-1:0]  hc_sts,
    input  logic              wr_en,
    input  logic [3:0]        wr_be,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              smi_req
);
    logic [N_EVT-1:0] evt_set;
    logic [N_EVT-1:0] evt_clr;
    logic [N_EVT-1:0] evt;
    logic [N_EVT-1:0] en;
    logic             sem_chg;
    logic             en_wr;
    logic             unused_wr_bits;

    smi_sem_edge #(.SEM_RST(SEM_RST)) u_sem (
        .clk   (clk),
        .rst_n (rst_sus_n),
        .sem_i (os_own_sem),
        .chg_o (sem_chg)
    );

    // Event sources in field order: BAR write, command write, semaphore.
    always_comb evt_set = {bar_wr_evt, cmd_wr_evt, sem_chg};

    for (genvar i = 0; i < N_EVT; i++) begin : g_clr
        // Write-1-to-clear qualified by the byte lane holding the bit.
        always_comb evt_clr[i] = wr_en && wr_be[(EVT_LSB + i) / 8] && wr_data[EVT_LSB + i];
    end

    smi_sticky_evt #(.N(N_EVT)) u_evt (
        .clk   (clk),
        .rst_n (rst_sus_n),
        .set_i (evt_set),
        .clr_i (evt_clr),
        .evt_o (evt)
    );

    // Enable field writes need its byte lane.
    always_comb en_wr = wr_en && wr_be[EN_LANE];

    smi_en_ctl #(.N(N_EVT)) u_en (
        .clk     (clk),
        .rst_n   (rst_sus_n),
        .en_wr_i (en_wr),
        .en_d_i  (wr_data[EN_LSB +: N_EVT]),
        .evt_i   (evt),
        .en_o    (en),
        .smi_o   (smi_req)
    );

    // Read word: events, live shadows, enables; everything else zero.
    always_comb begin
        rd_data = '0;
        rd_data[EVT_LSB +: N_EVT] = evt;
        rd_data[STS_LSB +: N_STS] = hc_sts;
        rd_data[EN_LSB  +: N_EVT] = en;
    end

    // Write-data bits with no storage behind them.
    assign unused_wr_bits = ^{wr_data[28:16], wr_data[12:0], wr_be[2], wr_be[0]};

    AST_SMI_RISE: assert property (@(posedge clk) disable iff (!rst_sus_n)
        (|(evt & en)) |=> smi_req); // R10
    AST_SMI_FALL: assert property (@(posedge clk) disable iff (!rst_sus_n)
        !(|(evt & en)) |=> !smi_req); // R10
    AST_BAR_SETS: assert property (@(posedge clk) disable iff (!rst_sus_n)
        bar_wr_evt |=> rd_data[31]); // R2
    AST_CMD_SETS: assert property (@(posedge clk) disable iff (!rst_sus_n)
        cmd_wr_evt |=> rd_data[30]); // R3
endmodule

// File: tb/smi_evt_reg_tb.sv
// Bench for smi_evt_reg: a behavioural model updated on each rising edge
// and compared 5 ns later, plus directed checks at the falling edge.
module smi_evt_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_sus_n = 1'b0;
    logic        bar_wr_evt = 1'b0;
    logic        cmd_wr_evt = 1'b0;
    logic        os_own_sem = 1'b0;
    logic [5:0]  hc_sts = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        smi_req;

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    // model state
    bit [2:0] m_evt = '0;
    bit [2:0] m_en = '0;
    bit       m_s1 = 1'b0, m_s2 = 1'b0, m_smi = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    smi_evt_reg dut_i (
        .clk(clk), .rst_sus_n(rst_sus_n), .bar_wr_evt(bar_wr_evt),
        .cmd_wr_evt(cmd_wr_evt), .os_own_sem(os_own_sem), .hc_sts(hc_sts),
        .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .rd_data(rd_data), .smi_req(smi_req)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%08h exp=%08h at %0t", req, got, exp, $time);
        end
    endtask

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        if (!rst_sus_n) begin
            m_evt = '0; m_en = '0; m_s1 = 1'b0; m_s2 = 1'b0; m_smi = 1'b0;
        end else begin
            bit nsmi, chg;
            bit [2:0] setv, clrv;
            nsmi = |(m_evt & m_en);
            chg  = m_s1 ^ m_s2;
            m_s2 = m_s1;
            m_s1 = os_own_sem;
            setv = {bar_wr_evt, cmd_wr_evt, chg};
            clrv = (wr_en && wr_be[3]) ? wr_data[31:29] : 3'b000;
            m_evt = (m_evt & ~clrv) | setv;
            if (wr_en && wr_be[1]) m_en = wr_data[15:13];
            m_smi = nsmi;
        end
    end

    // Cycle compare against the model, between edge and next drive.
    always @(posedge clk) begin
        #5;
        chk({tag, " word"}, rd_data, {m_evt, 7'b0, hc_sts, m_en, 13'b0});
        chk({tag, " smi"}, {31'b0, smi_req}, {31'b0, m_smi});
    end

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] be, input logic [31:0] d);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        step();
        wr_en = 1'b0; wr_be = '0; wr_data = '0;
    endtask

    task automatic pulse_bar();
        bar_wr_evt = 1'b1; step(); bar_wr_evt = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(3);
        rst_sus_n = 1'b1;
        step(2);
        tag = "R1";
        chk("R1 reset word", rd_data, 32'h0);
        chk("R1 reset smi", {31'b0, smi_req}, 32'h0);
        step(2);
        chk("R4 no event from reset", rd_data, 32'h0);

        tag = "R2";
        pulse_bar();
        chk("R2 bar sets bit31", rd_data, 32'h8000_0000);
        tag = "R5";
        wr(4'hF, 32'h0000_0000);
        chk("R5 write 0 keeps bit31", rd_data, 32'h8000_0000);
        wr(4'h7, 32'hFFFF_FFFF);
        chk("R5 lane 3 off keeps bit31", rd_data[31:29], 32'h4);
        wr(4'h2, 32'h0);
        tag = "R2";
        wr(4'h8, 32'h8000_0000);
        chk("R2 W1C bit31", rd_data, 32'h0);

        tag = "R3";
        cmd_wr_evt = 1'b1; step(); cmd_wr_evt = 1'b0;
        chk("R3 cmd sets bit30", rd_data, 32'h4000_0000);
        wr(4'h8, 32'h4000_0000);
        chk("R3 W1C bit30", rd_data, 32'h0);

        tag = "R4";
        os_own_sem = 1'b1; step();
        chk("R4 rise not yet", rd_data[29], 32'h0);
        step();
        chk("R4 rise sets bit29", rd_data[29], 32'h1);
        wr(4'h8, 32'h2000_0000);
        chk("R4 W1C bit29", rd_data[29], 32'h0);
        os_own_sem = 1'b0; step(2);
        chk("R4 fall sets bit29", rd_data[29], 32'h1);
        wr(4'h8, 32'h2000_0000);

        tag = "R6";
        bar_wr_evt = 1'b1; cmd_wr_evt = 1'b1;
        wr(4'h8, 32'hE000_0000);
        bar_wr_evt = 1'b0; cmd_wr_evt = 1'b0;
        chk("R6 set beats clear", rd_data[31:29], 32'h6);
        wr(4'h8, 32'hE000_0000);

        tag = "R7";
        for (int p = 0; p < 64; p += 21) begin
            hc_sts = p[5:0];
            wr(4'hF, 32'hFFFF_FFFF);
            chk("R7 shadow follows input", rd_data[21:16], p);
            chk("R9 reserved read 0", {rd_data[28:22], rd_data[12:0]}, 32'h0);
            wr(4'hF, 32'h0);
        end
        hc_sts = 6'b100001; step();
        chk("R7 shadow order", rd_data, 32'h0021_0000);
        hc_sts = '0;

        tag = "R8";
        wr(4'h2, 32'h0000_A000);
        chk("R8 enables load", rd_data, 32'h0000_A000);
        wr(4'h1, 32'h0000_0000);
        chk("R8 lane 1 off keeps", rd_data, 32'h0000_A000);

        tag = "R10";
        pulse_bar();
        chk("R10 smi not same cycle", {31'b0, smi_req}, 32'h0);
        step();
        chk("R10 smi after one edge", {31'b0, smi_req}, 32'h1);
        wr(4'h8, 32'h8000_0000);
        chk("R10 smi still set one edge", {31'b0, smi_req}, 32'h1);
        step();
        chk("R10 smi drops", {31'b0, smi_req}, 32'h0);
        cmd_wr_evt = 1'b1; step(); cmd_wr_evt = 1'b0; step();
        chk("R10 disabled event no smi", {31'b0, smi_req}, 32'h0);
        wr(4'h2, 32'h0000_4000);
        step();
        chk("R10 enabling later raises smi", {31'b0, smi_req}, 32'h1);

        tag = "R11";
        rst_sus_n = 1'b0;
        bar_wr_evt = 1'b1; step(); bar_wr_evt = 1'b0;
        chk("R11 reset clears all", rd_data, 32'h0);
        chk("R11 reset clears smi", {31'b0, smi_req}, 32'h0);
        rst_sus_n = 1'b1; step(3);
        chk("R11 event in reset dropped", rd_data, 32'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule